// File: doc/BRIEF.md
# Prioritised Peripheral Pin Multiplexer Port

This block is an 8-pin general-purpose I/O port. Each pin can be taken over by one of several on-chip peripheral functions. Every pin pair has its own fixed priority chain. The highest enabled function in a chain owns both pins of the pair. A pair with no enabled function falls back to GPIO and is driven from a data register, gated by a direction register. Both registers sit on a simple single-cycle register bus.

Peripherals give the port an enable and, for each pin of their pair, an output value and an output enable. The port returns a receive input to each peripheral from its pads. Some chains hold alternate instances of a peripheral that are reached over a second pin pair. Arbitration is purely combinational, so the pads follow the enables with no added latency.

Top module: `pinmux_port`

## Requirements
- R1: After reset the data and direction registers are 0x00, and with no function enabled every pad output enable is 0.
- R2: A write with `reg_we_i` high at address 0 (data) or address 1 (direction) loads `reg_wdata_i` at that clock edge. A write to any other address changes neither register, and reads of other addresses return 0.
- R3: Reading address 0 returns, for each bit, the data latch where the direction bit is 1 and `pad_i` where it is 0. Reading address 1 returns the direction register. Reads are combinational.
- R4: A pair with no enabled function drives `pad_o` from the data register and `pad_oe_o` from the direction register.
- R5: Function lanes in the `fn_*` ports use this index: 0 CAN0, 1 CAN1, 2 CAN2, 3 CAN3, 4 CAN4, 5 SCI3, 6 alternate CAN0, 7 alternate CAN4, 8 alternate SPI0. Bit 1 of a lane is the higher pin of its pair. On pins 7/6 the priority is CAN3, then CAN4, then SCI3, then GPIO.
- R6: On pins 5/4 the priority is CAN2, then alternate CAN0, then alternate CAN4, then alternate SPI0, then GPIO.
- R7: Pins 3/2 are owned by CAN1 when it is enabled, and pins 1/0 by CAN0 when it is enabled. Otherwise these pairs are GPIO.
- R8: For every CAN and SCI function, the higher pin transmits (output enable 1, value from the lane's bit 1) and the lower pin receives (output enable 0, value 0). Alternate SPI0 drives both pins with its own output and output-enable bits, carrying serial clock on pin 5 and master-out data on pin 4.
- R9: The owning function's `fn_in_o` lane carries its pair's `pad_i` bits. Every function that does not own its pair sees `fn_in_o` = 2'b11.
- R10: A data-register write while a function owns the pair updates the latch but not the pad. The latched value reaches the pad once the pair returns to GPIO.
- R11: A change of any enable, peripheral output or pad input appears on `pad_o`, `pad_oe_o` and `fn_in_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address (0 data, 1 direction) |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| fn_en_i | input | 9 | Per-function enable |
| fn_out_i | input | 9x2 | Per-function pin output values |
| fn_oe_i | input | 9x2 | Per-function pin output enables (used by bidirectional functions) |
| fn_in_o | output | 9x2 | Per-function receive inputs from pads |
| pad_i | input | 8 | Buffered pad inputs |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
Pad outputs, function inputs and read data are combinational. Each is therefore checked one nanosecond after the stimulus is applied on the falling edge, within the same cycle. Register writes become visible only after the next rising edge. The bench model updates its register copies only after that edge, and reads are compared on the following falling edge. The random stimulus includes writes made while a function owns a pair. This exercises the split between latch state, read data and pad output.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_PINS  = 8;
  localparam int NUM_PAIRS = NUM_PINS / 2;
  localparam int NUM_FN    = 9;
  localparam int CHAIN_LEN = 4;
  localparam int FN_NONE   = -1;

  localparam int FN_CAN0  = 0;
  localparam int FN_CAN1  = 1;
  localparam int FN_CAN2  = 2;
  localparam int FN_CAN3  = 3;
  localparam int FN_CAN4  = 4;
  localparam int FN_SCI3  = 5;
  localparam int FN_RCAN0 = 6;
  localparam int FN_RCAN4 = 7;
  localparam int FN_RSPI0 = 8;

  typedef enum logic [1:0] {PK_TX, PK_RX, PK_BIDIR} pin_kind_e;

  // slot 0 is the highest priority
  function automatic int chain_fn(input int pair, input int slot);
    case (pair)
      3: case (slot)
           0: return FN_CAN3;
           1: return FN_CAN4;
           2: return FN_SCI3;
           default: return FN_NONE;
         endcase
      2: case (slot)
           0: return FN_CAN2;
           1: return FN_RCAN0;
           2: return FN_RCAN4;
           3: return FN_RSPI0;
           default: return FN_NONE;
         endcase
      1: return (slot == 0) ? FN_CAN1 : FN_NONE;
      0: return (slot == 0) ? FN_CAN0 : FN_NONE;
      default: return FN_NONE;
    endcase
  endfunction

  function automatic pin_kind_e fn_kind(input int fn, input bit hi);
    if (fn == FN_RSPI0) return PK_BIDIR;
    return hi ? PK_TX : PK_RX;
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
  parameter int ADDR_W    = 4,
  parameter int NUM_PINS  = 8,
  parameter int DATA_ADDR = 0,
  parameter int DIR_ADDR  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] dat_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] DataA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] DirA  = ADDR_W'(DIR_ADDR);

  logic [NUM_PINS-1:0] dat_q, dir_q;
  logic dat_wr, dir_wr;

  assign dat_wr = we_i && (addr_i == DataA);
  assign dir_wr = we_i && (addr_i == DirA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (dat_wr) dat_q <= wdata_i;
      if (dir_wr) dir_q <= wdata_i;
    end
  end

  // output bits read latch, input bits read the pad
  always_comb begin
    unique case (addr_i)
      DataA:   rdata_o = (dir_q & dat_q) | (~dir_q & pad_in_i);
      DirA:    rdata_o = dir_q;
      default: rdata_o = '0;
    endcase
  end

  assign dat_o = dat_q;
  assign dir_o = dir_q;

  // R2
  dat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DataA) |=> (dat_o == $past(wdata_i)));
  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DirA) |=> (dir_o == $past(wdata_i)));
  // R2
  dat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == DataA) |=> $stable(dat_o));
  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == DirA) |=> $stable(dir_o));
endmodule

// File: rtl/pinmux_pair_arb.sv
module pinmux_pair_arb
  import pinmux_pkg::*;
#(
  parameter int PAIR = 0
) (
  input  logic [NUM_FN-1:0]       fn_en_i,
  input  logic [NUM_FN-1:0][1:0]  fn_out_i,
  input  logic [NUM_FN-1:0][1:0]  fn_oe_i,
  input  logic [1:0]              gpio_out_i,
  input  logic [1:0]              gpio_oe_i,
  output logic [1:0]              pad_o,
  output logic [1:0]              pad_oe_o,
  output logic [NUM_FN-1:0]       own_o
);
  int win;

  always_comb begin
    win = FN_NONE;
    for (int s = CHAIN_LEN - 1; s >= 0; s--) begin
      if (chain_fn(PAIR, s) != FN_NONE && fn_en_i[chain_fn(PAIR, s)])
        win = chain_fn(PAIR, s);
    end
  end

  always_comb begin
    own_o    = '0;
    pad_o    = gpio_out_i;
    pad_oe_o = gpio_oe_i;
    if (win != FN_NONE) begin
      own_o[win] = 1'b1;
      for (int h = 0; h < 2; h++) begin
        unique case (fn_kind(win, h[0]))
          PK_TX: begin
            pad_o[h]    = fn_out_i[win][h];
            pad_oe_o[h] = 1'b1;
          end
          PK_RX: begin
            pad_o[h]    = 1'b0;
            pad_oe_o[h] = 1'b0;
          end
          default: begin
            pad_o[h]    = fn_out_i[win][h];
            pad_oe_o[h] = fn_oe_i[win][h];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route
  import pinmux_pkg::*;
(
  input  logic [NUM_PAIRS-1:0][NUM_FN-1:0] own_i,
  input  logic [NUM_PINS-1:0]              pad_i,
  output logic [NUM_FN-1:0][1:0]           fn_in_o
);
  // non-owners idle high
  always_comb begin
    fn_in_o = '1;
    for (int p = 0; p < NUM_PAIRS; p++)
      for (int f = 0; f < NUM_FN; f++)
        if (own_i[p][f]) fn_in_o[f] = pad_i[2*p +: 2];
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic                   reg_we_i,
  input  logic [NUM_PINS-1:0]    reg_wdata_i,
  output logic [NUM_PINS-1:0]    reg_rdata_o,
  input  logic [NUM_FN-1:0]      fn_en_i,
  input  logic [NUM_FN-1:0][1:0] fn_out_i,
  input  logic [NUM_FN-1:0][1:0] fn_oe_i,
  output logic [NUM_FN-1:0][1:0] fn_in_o,
  input  logic [NUM_PINS-1:0]    pad_i,
  output logic [NUM_PINS-1:0]    pad_o,
  output logic [NUM_PINS-1:0]    pad_oe_o
);
  logic [NUM_PINS-1:0] dat, dir;
  logic [NUM_PAIRS-1:0][NUM_FN-1:0] own;

  pinmux_regs #(
    .ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS), .DATA_ADDR(0), .DIR_ADDR(1)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .pad_in_i (pad_i),
    .dat_o    (dat),
    .dir_o    (dir),
    .rdata_o  (reg_rdata_o)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pinmux_pair_arb #(.PAIR(p)) u_arb (
      .fn_en_i    (fn_en_i),
      .fn_out_i   (fn_out_i),
      .fn_oe_i    (fn_oe_i),
      .gpio_out_i (dat[2*p +: 2]),
      .gpio_oe_i  (dir[2*p +: 2]),
      .pad_o      (pad_o[2*p +: 2]),
      .pad_oe_o   (pad_oe_o[2*p +: 2]),
      .own_o      (own[p])
    );

    // R4
    gpio_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own[p] == '0) |-> (pad_oe_o[2*p +: 2] == dir[2*p +: 2] &&
                          pad_o[2*p +: 2] == dat[2*p +: 2]));
    // R5 R6 R7
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(own[p]));
    // R8
    top_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn_en_i[chain_fn(p, 0)] |-> (pad_oe_o[2*p+1] && !pad_oe_o[2*p] &&
                                   pad_o[2*p+1] == fn_out_i[chain_fn(p, 0)][1]));
  end

  pinmux_in_route u_route (
    .own_i   (own),
    .pad_i   (pad_i),
    .fn_in_o (fn_in_o)
  );

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn_chk
    logic owned;
    always_comb begin
      owned = 1'b0;
      for (int p = 0; p < NUM_PAIRS; p++) owned |= own[p][f];
    end
    // R9
    idle_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !owned |-> (fn_in_o[f] == 2'b11));
    // R9
    not_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fn_en_i[f] |-> !owned);
  end
endmodule

// File: tb/pinmux_port_tb.sv
module pinmux_port_tb;
  localparam int NF = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic we = 1'b0;
  logic [7:0] wdata = '0, rdata, pad_in = '0, pad_o, pad_oe;
  logic [NF-1:0] en = '0;
  logic [NF-1:0][1:0] fout = '0, foe = '0, fin;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_dat = '0, m_dir = '0;

  always #2 clk = ~clk;

  pinmux_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fn_en_i(en), .fn_out_i(fout),
    .fn_oe_i(foe), .fn_in_o(fin), .pad_i(pad_in), .pad_o(pad_o), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // priority chains per R5/R6/R7
  function automatic int chain(input int p, input int s);
    int t[4][4] = '{'{0, -1, -1, -1}, '{1, -1, -1, -1}, '{2, 6, 7, 8}, '{3, 4, 5, -1}};
    return t[p][s];
  endfunction

  task automatic model(output logic [7:0] po, output logic [7:0] poe,
                       output logic [NF-1:0][1:0] fi, output logic [7:0] rd);
    fi = '1;
    for (int p = 0; p < 4; p++) begin
      int w = -1;
      for (int s = 0; s < 4; s++)
        if (w < 0 && chain(p, s) >= 0 && en[chain(p, s)]) w = chain(p, s);
      if (w < 0) begin
        po[2*p +: 2] = m_dat[2*p +: 2];
        poe[2*p +: 2] = m_dir[2*p +: 2];
      end else begin
        fi[w] = pad_in[2*p +: 2];
        if (w == 8) begin
          po[2*p +: 2] = fout[w];
          poe[2*p +: 2] = foe[w];
        end else begin
          po[2*p +: 2] = {fout[w][1], 1'b0};
          poe[2*p +: 2] = 2'b10;
        end
      end
    end
    case (addr)
      4'd0: rd = (m_dir & m_dat) | (~m_dir & pad_in);
      4'd1: rd = m_dir;
      default: rd = '0;
    endcase
  endtask

  task automatic check_all(input string tag);
    logic [7:0] po, poe, rd;
    logic [NF-1:0][1:0] fi;
    model(po, poe, fi, rd);
    chk({tag, " pad_o"}, 32'(pad_o), 32'(po));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(poe));
    chk({tag, " fn_in"}, 32'(fin), 32'(fi));
    chk({tag, " rdata"}, 32'(rdata), 32'(rd));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    if (a == 0) m_dat = d;
    if (a == 1) m_dir = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle(); #1; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    pad_in = 8'h5A;
    #10 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    addr = 4'd1; settle();
    chk("R1 dir reset", 32'(rdata), 0);
    chk("R1 oe reset", 32'(pad_oe), 0);
    addr = 4'd0; settle();
    chk("R1 R3 data read all inputs", 32'(rdata), 32'h5A);

    // R2 R4 GPIO output
    wr(4'd1, 8'hFF); wr(4'd0, 8'hA5);
    addr = 4'd0; settle();
    chk("R4 pad_o gpio", 32'(pad_o), 32'hA5);
    chk("R4 pad_oe gpio", 32'(pad_oe), 32'hFF);
    chk("R2 R3 readback latch", 32'(rdata), 32'hA5);

    // R3 mixed direction
    wr(4'd1, 8'h0F); pad_in = 8'h3C; addr = 4'd0; settle();
    chk("R3 mixed read", 32'(rdata), 32'h35);

    // R2 write to unused address ignored
    wr(4'd5, 8'h77); settle();
    chk("R2 unused addr read", 32'(rdata), 0);
    addr = 4'd1; settle();
    chk("R2 dir untouched", 32'(rdata), 32'h0F);
    addr = 4'd0; settle();
    chk("R2 data untouched", 32'(rdata), 32'h35);

    // R5 R8 R9 R11 pins 7/6, same-cycle ownership
    wr(4'd1, 8'hFF);
    @(negedge clk);
    pad_in = 8'b1000_0000;
    en[3] = 1; en[4] = 1; en[5] = 1; fout[3] = 2'b10; fout[4] = 2'b00;
    settle();
    chk("R5 R11 can3 tx pad7", 32'(pad_o[7]), 1);
    chk("R8 can3 oe 7/6", 32'(pad_oe[7:6]), 32'b10);
    chk("R9 can3 rx input", 32'(fin[3]), 32'b10);
    chk("R9 can4 idle", 32'(fin[4]), 32'b11);
    en[3] = 0; settle();
    chk("R5 can4 wins", 32'(pad_o[7]), 0);
    chk("R9 can4 owns input", 32'(fin[4]), 32'b10);
    en[4] = 0; fout[5] = 2'b11; settle();
    chk("R5 sci3 tx", 32'(pad_o[7:6]), 32'b10);
    chk("R9 sci3 input", 32'(fin[5]), 32'b10);
    en[5] = 0; settle();
    chk("R5 back to gpio", 32'(pad_o[7:6]), 32'(m_dat[7:6]));

    // R6 R8 pins 5/4
    en[7] = 1; en[8] = 1; fout[7] = 2'b10; fout[8] = 2'b01; foe[8] = 2'b11;
    settle();
    chk("R6 rcan4 over rspi0", 32'({pad_o[5:4], pad_oe[5:4]}), 32'b10_10);
    en[6] = 1; fout[6] = 2'b00; settle();
    chk("R6 rcan0 over rcan4", 32'(pad_o[5]), 0);
    chk("R9 rcan4 idle", 32'(fin[7]), 32'b11);
    en[2] = 1; fout[2] = 2'b10; settle();
    chk("R6 can2 top", 32'(pad_o[5]), 1);
    en[2] = 0; en[6] = 0; en[7] = 0; foe[8] = 2'b01; settle();
    chk("R8 rspi0 bidir", 32'({pad_o[5:4], pad_oe[5:4]}), 32'b01_01);
    en[8] = 0;

    // R7 low pairs
    en[1] = 1; en[0] = 1; fout[1] = 2'b10; fout[0] = 2'b00; pad_in = 8'h0B; settle();
    chk("R7 R8 can1 can0 pads", 32'({pad_o[3:0], pad_oe[3:0]}), 32'b1000_1010);
    chk("R7 R9 can1 input", 32'(fin[1]), 32'b10);
    chk("R7 R9 can0 input", 32'(fin[0]), 32'b11);
    en[1] = 0; en[0] = 0;

    // R10 write under ownership
    en[3] = 1; fout[3] = 2'b00;
    wr(4'd0, 8'hC0); addr = 4'd0; settle();
    chk("R10 pad held by owner", 32'(pad_o[7]), 0);
    chk("R10 latch readable", 32'(rdata), 32'hC0);
    en[3] = 0; settle();
    chk("R10 latch reaches pad", 32'(pad_o[7:6]), 32'b11);

    // random mix, R4 R5 R6 R7 R8 R9 R3 R2
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int f = 0; f < NF; f++) en[f] = ($urandom % 3) == 0;
      fout = NF*2'($urandom);
      foe = NF*2'($urandom);
      pad_in = 8'($urandom);
      addr = 4'($urandom % 4);
      we = $urandom % 2;
      wdata = 8'($urandom);
      settle();
      check_all("R4 R5 R6 R7 R8 R9 R3 random");
      @(posedge clk);
      if (we && addr == 0) m_dat = wdata;
      if (we && addr == 1) m_dir = wdata;
    end
    @(negedge clk);
    we = 0;
    finish_run();
  end
endmodule